// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds eight one-bit ownership tokens shared by two independent ports, a left port and a right port. It sits in an address space of its own, entered through a per-port select. Software on either side claims a token by writing a zero to it, and then confirms the claim by reading the token back. A value of zero means "this side owns it". Writing a one gives the token up.

Each side has a request latch for every token. When a side asks for a token that the other side already holds, its request is not lost. The request stays pending, and the token passes to that side on the same clock edge at which the owner releases it. If both sides ask for a free token in the same cycle, the left side wins by fixed priority and the right request becomes pending.

Reads are captured at the start of an access and held while it lasts. The token value is spread across all nine output bits. A polling loop must end its access, by dropping select or output enable, before a new read can show a change.

Top module: `sem_bank_top`

## Requirements
- R1: After synchronous active-low reset, every token is free: both ports read all ones on every index, and an idle port drives 9'h1FF.
- R2: The 3-bit index selects one of eight tokens. A write changes only the indexed token.
- R3: A write with select=1, write enable=1 and data bit 0 = 0 to a free token makes that side the owner. The owner reads 9'h000, and the other side reads 9'h1FF. A later 0 from the other side does not take the token away.
- R4: A 0 written by the non-owning side is held as a pending request. When the owner writes 1, ownership passes to the pending side at that same clock edge.
- R5: When both sides write 0 to the same free token in the same cycle, the left side becomes the owner and the right request stays pending.
- R6: A read access is select=1, output enable=1 and write enable=0. Its data is the requesting side's flag copied onto all nine bits: 9'h000 when that side owns the token, 9'h1FF otherwise. The output shows this from the cycle after the access starts. When no access is active, the output is 9'h1FF.
- R7: The read value and index are captured in the first cycle of an access and held until select or output enable drops. Index changes and token changes during the access do not show.
- R8: A write of 1 from a side that does not own the token does not free it. It only withdraws that side's pending request, so no hand-over follows a later release.
- R9: When the owner writes 1 and there is no pending request from the other side, the token becomes free and both sides read 9'h1FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lf_sel | input | 1 | Left semaphore-space select |
| lf_oe | input | 1 | Left output enable |
| lf_we | input | 1 | Left write enable |
| lf_idx | input | 3 | Left token index |
| lf_din | input | 1 | Left write data bit 0 |
| lf_dout | output | 9 | Left read data |
| rt_sel | input | 1 | Right semaphore-space select |
| rt_oe | input | 1 | Right output enable |
| rt_we | input | 1 | Right write enable |
| rt_idx | input | 3 | Right token index |
| rt_din | input | 1 | Right write data bit 0 |
| rt_dout | output | 9 | Right read data |

## Verification
The bench targets four cases.

- Hand-over on release. A design without a pending latch would leave the token free instead of giving it to the waiting side.
- A withdrawn request. A design that never clears the request latch would hand the token to a side that has given up.
- The same-cycle tie. A flawed design could grant the token to both sides, to neither, or to the right side.
- The held read. The bench changes the index during an active access and expects the first value to stay. A design that decodes live would show the new token instead.

// File: rtl/sem_pkg.sv
// Shared constants and types for the semaphore token bank.
// Assumes the index width is enough to address every token.
package sem_pkg;
    localparam int unsigned SEM_TOKENS = 8;
    localparam int unsigned SEM_IDXW   = $clog2(SEM_TOKENS);
    localparam int unsigned SEM_DW     = 9;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_LF   = 2'd1,
        OWN_RT   = 2'd2
    } owner_t;
endpackage

// File: rtl/sem_token.sv
// One ownership token with a request latch per side.
// Ownership follows the requests: a held token stays with its owner
// while the owner's request stands, then passes to the other side's
// pending request, if one exists. A tie on a free token goes left.
// Assumes the write strobes are already qualified by select and index.
module sem_token
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_l,
    input  logic din_l,
    input  logic wr_r,
    input  logic din_r,
    output logic own_l,
    output logic own_r
);
    logic   rq_l, rq_r, rq_l_n, rq_r_n;
    owner_t owner, owner_n;

    // Next request latches: a write stores the inverted data bit.
    always_comb begin
        rq_l_n = wr_l ? ~din_l : rq_l;
        rq_r_n = wr_r ? ~din_r : rq_r;
    end

    // Next owner: keep while requested, else hand over, else free.
    always_comb begin
        case (owner)
            OWN_LF:  owner_n = rq_l_n ? OWN_LF : (rq_r_n ? OWN_RT : OWN_NONE);
            OWN_RT:  owner_n = rq_r_n ? OWN_RT : (rq_l_n ? OWN_LF : OWN_NONE);
            default: owner_n = rq_l_n ? OWN_LF : (rq_r_n ? OWN_RT : OWN_NONE);
        endcase
    end

    // State registers, all tokens free after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_l  <= 1'b0;
            rq_r  <= 1'b0;
            owner <= OWN_NONE;
        end else begin
            rq_l  <= rq_l_n;
            rq_r  <= rq_r_n;
            owner <= owner_n;
        end
    end

    assign own_l = (owner == OWN_LF);
    assign own_r = (owner == OWN_RT);

    AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        own_l && !(wr_l && din_l) |=> own_l); // R3
    AST_FOREIGN_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        own_r && !(wr_r && din_r) |=> own_r); // R8
    AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        own_l && wr_l && din_l && rq_r && !(wr_r && din_r) |=> own_r); // R4
    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        !own_l && !own_r && wr_l && !din_l |=> own_l); // R5
endmodule

// File: rtl/sem_read_port.sv
// Read side of one port. Captures the indexed flag in the first cycle
// of an access and holds it, spread over every bit, until the access ends.
// Assumes view[i] is 0 when this side owns token i.
module sem_read_port #(
    parameter int unsigned TOKENS = 8,
    parameter int unsigned DW     = 9,
    localparam int unsigned IDXW  = $clog2(TOKENS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              oe,
    input  logic              we,
    input  logic [IDXW-1:0]   idx,
    input  logic [TOKENS-1:0] view,
    output logic [DW-1:0]     dout
);
    logic rd_act, act_q, hold;

    assign rd_act = sel & oe & ~we;

    // Capture on the first access cycle, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            hold  <= 1'b1;
        end else begin
            act_q <= rd_act;
            if (rd_act && !act_q) hold <= view[idx];
        end
    end

    assign dout = act_q ? {DW{hold}} : {DW{1'b1}};

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        act_q && $past(act_q) |-> $stable(dout)); // R7
    always_comb begin
        AST_REPLICATED: assert (dout == '0 || dout == '1); // R6
    end
endmodule

// File: rtl/sem_bank_top.sv
// Two-port bank of semaphore tokens. Decodes each port's writes onto
// the indexed token and feeds each port's view of the flags to its reader.
// Assumes a port never writes and reads in the same cycle (we selects).
module sem_bank_top
    import sem_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lf_sel,
    input  logic                lf_oe,
    input  logic                lf_we,
    input  logic [SEM_IDXW-1:0] lf_idx,
    input  logic                lf_din,
    output logic [SEM_DW-1:0]   lf_dout,
    input  logic                rt_sel,
    input  logic                rt_oe,
    input  logic                rt_we,
    input  logic [SEM_IDXW-1:0] rt_idx,
    input  logic                rt_din,
    output logic [SEM_DW-1:0]   rt_dout
);
    logic [SEM_TOKENS-1:0] own_l, own_r;
    logic                  lf_wr, rt_wr;

    assign lf_wr = lf_sel & lf_we;
    assign rt_wr = rt_sel & rt_we;

    for (genvar i = 0; i < SEM_TOKENS; i++) begin : g_tok
        sem_token u_tok (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_l  (lf_wr && (lf_idx == SEM_IDXW'(i))),
            .din_l (lf_din),
            .wr_r  (rt_wr && (rt_idx == SEM_IDXW'(i))),
            .din_r (rt_din),
            .own_l (own_l[i]),
            .own_r (own_r[i])
        );
    end

    sem_read_port #(.TOKENS(SEM_TOKENS), .DW(SEM_DW)) u_rd_lf (
        .clk (clk), .rst_n (rst_n), .sel (lf_sel), .oe (lf_oe), .we (lf_we),
        .idx (lf_idx), .view (~own_l), .dout (lf_dout)
    );

    sem_read_port #(.TOKENS(SEM_TOKENS), .DW(SEM_DW)) u_rd_rt (
        .clk (clk), .rst_n (rst_n), .sel (rt_sel), .oe (rt_oe), .we (rt_we),
        .idx (rt_idx), .view (~own_r), .dout (rt_dout)
    );

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0); // R3
endmodule

// File: tb/sem_bank_test.sv
`timescale 1ns/100ps
module sem_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lf_sel = 0, lf_oe = 0, lf_we = 0, lf_din = 0;
    logic       rt_sel = 0, rt_oe = 0, rt_we = 0, rt_din = 0;
    logic [2:0] lf_idx = 0, rt_idx = 0;
    logic [8:0] lf_dout, rt_dout;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sem_bank_top uut (
        .clk(clk), .rst_n(rst_n),
        .lf_sel(lf_sel), .lf_oe(lf_oe), .lf_we(lf_we), .lf_idx(lf_idx),
        .lf_din(lf_din), .lf_dout(lf_dout),
        .rt_sel(rt_sel), .rt_oe(rt_oe), .rt_we(rt_we), .rt_idx(rt_idx),
        .rt_din(rt_din), .rt_dout(rt_dout)
    );

    // Behavioural reference: owner 0 free, 1 left, 2 right.
    int owner [8];
    bit rq_l [8];
    bit rq_r [8];
    bit act_q [2];
    bit hold  [2];

    always @(posedge clk) begin
        bit nl, nr;
        bit a_l, a_r;
        if (!rst_n) begin
            foreach (owner[i]) begin owner[i] = 0; rq_l[i] = 0; rq_r[i] = 0; end
            act_q[0] = 0; act_q[1] = 0; hold[0] = 1; hold[1] = 1;
        end else begin
            a_l = lf_sel && lf_oe && !lf_we;
            a_r = rt_sel && rt_oe && !rt_we;
            if (a_l && !act_q[0]) hold[0] = (owner[lf_idx] != 1);
            if (a_r && !act_q[1]) hold[1] = (owner[rt_idx] != 2);
            act_q[0] = a_l; act_q[1] = a_r;
            for (int i = 0; i < 8; i++) begin
                nl = (lf_sel && lf_we && lf_idx == i) ? !lf_din : rq_l[i];
                nr = (rt_sel && rt_we && rt_idx == i) ? !rt_din : rq_r[i];
                rq_l[i] = nl; rq_r[i] = nr;
                if (owner[i] == 2) owner[i] = nr ? 2 : (nl ? 1 : 0);
                else               owner[i] = (owner[i] == 1 && nl) ? 1 :
                                              (owner[i] == 1 ? (nr ? 2 : 0) :
                                              (nl ? 1 : (nr ? 2 : 0)));
            end
        end
    end

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model (R6, R7).
    always @(negedge clk) if (rst_n) begin
        check("R6 model left",  lf_dout, act_q[0] ? {9{hold[0]}} : 9'h1FF);
        check("R7 model right", rt_dout, act_q[1] ? {9{hold[1]}} : 9'h1FF);
    end

    task automatic wr(input bit side, input logic [2:0] idx, input bit d);
        if (!side) begin lf_sel = 1; lf_we = 1; lf_idx = idx; lf_din = d; end
        else       begin rt_sel = 1; rt_we = 1; rt_idx = idx; rt_din = d; end
        @(negedge clk);
        lf_sel = 0; lf_we = 0; rt_sel = 0; rt_we = 0;
    endtask

    task automatic rd(input bit side, input logic [2:0] idx, input logic [8:0] exp, input string req);
        if (!side) begin lf_sel = 1; lf_oe = 1; lf_idx = idx; end
        else       begin rt_sel = 1; rt_oe = 1; rt_idx = idx; end
        @(negedge clk);
        check(req, side ? rt_dout : lf_dout, exp);
        lf_sel = 0; lf_oe = 0; rt_sel = 0; rt_oe = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle left", lf_dout, 9'h1FF);
        check("R1 idle right", rt_dout, 9'h1FF);
        for (int i = 0; i < 8; i++) rd(0, i[2:0], 9'h1FF, "R1 free left");
        rd(1, 3'd7, 9'h1FF, "R1 free right");

        wr(0, 3'd3, 0);
        rd(0, 3'd3, 9'h000, "R3 owner reads 0");
        rd(1, 3'd3, 9'h1FF, "R3 other reads 1");
        rd(0, 3'd2, 9'h1FF, "R2 neighbour untouched");
        rd(0, 3'd4, 9'h1FF, "R2 neighbour untouched");

        wr(1, 3'd3, 0);
        rd(0, 3'd3, 9'h000, "R3 no steal");
        rd(1, 3'd3, 9'h1FF, "R3 pending not owner");
        wr(1, 3'd3, 1);
        rd(0, 3'd3, 9'h000, "R8 foreign 1 ignored");
        wr(0, 3'd3, 1);
        rd(0, 3'd3, 9'h1FF, "R9 freed left");
        rd(1, 3'd3, 9'h1FF, "R8 withdrawn no handover");

        wr(0, 3'd6, 0);
        wr(1, 3'd6, 0);
        wr(0, 3'd6, 1);
        rd(1, 3'd6, 9'h000, "R4 handover right");
        rd(0, 3'd6, 9'h1FF, "R4 left lost");
        wr(1, 3'd6, 1);
        rd(1, 3'd6, 9'h1FF, "R9 freed both");

        lf_sel = 1; lf_we = 1; lf_idx = 3'd1; lf_din = 0;
        rt_sel = 1; rt_we = 1; rt_idx = 3'd1; rt_din = 0;
        @(negedge clk);
        lf_sel = 0; lf_we = 0; rt_sel = 0; rt_we = 0;
        rd(0, 3'd1, 9'h000, "R5 tie left wins");
        rd(1, 3'd1, 9'h1FF, "R5 tie right pending");
        wr(0, 3'd1, 1);
        rd(1, 3'd1, 9'h000, "R4 tie pending takes over");

        rt_sel = 1; rt_oe = 1; rt_idx = 3'd2;
        @(negedge clk);
        check("R7 first value", rt_dout, 9'h1FF);
        rt_idx = 3'd1;
        @(negedge clk);
        check("R7 held across index change", rt_dout, 9'h1FF);
        @(negedge clk);
        check("R7 still held", rt_dout, 9'h1FF);
        rt_oe = 0;
        @(negedge clk);
        check("R6 idle after access", rt_dout, 9'h1FF);
        rt_oe = 1;
        @(negedge clk);
        check("R7 new access sees token", rt_dout, 9'h000);
        rt_sel = 0; rt_oe = 0;
        @(negedge clk);

        wr(0, 3'd7, 0);
        lf_sel = 1; lf_oe = 1; lf_idx = 3'd7;
        @(negedge clk);
        check("R6 all bits zero", lf_dout, 9'h000);
        lf_idx = 3'd0;
        @(negedge clk);
        check("R7 left held", lf_dout, 9'h000);
        lf_sel = 0; lf_oe = 0;
        @(negedge clk);
        rd(0, 3'd0, 9'h1FF, "R2 token 0 untouched");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule